// File: doc/BRIEF.md
# Serial GF(2) Polynomial Divider for Signature Compaction

This block compacts a single serial response stream from a circuit under test into a short signature. It is a shift register with internal feedback. Each enabled clock takes one input bit into cell 0 and moves every cell one place towards the high end. The bit that leaves the top cell is fed back, through XOR gates, into every cell whose tap is set. Viewed as arithmetic, the register divides the dividend polynomial carried by the input stream (highest-order coefficient first) by a fixed divisor `x^WIDTH + sum(TAPS[i]·x^i)`. The bits leaving the top cell form the quotient, and the final register contents form the remainder.

In use, a test controller pulses `clr` to start a run. It then holds `en` high while the circuit under test delivers its response bits on `din`, and finally pulses `chk`. One cycle after `chk`, the block raises `vld` for one cycle and gives a go/no-go flag `pass`, which is set when the signature equals the parameter `EXPECT`. The asynchronous reset is released through a two-stage synchronizer. The quotient stream on `qout` allows the block to be used as a general serial polynomial divider as well as a compactor.

Top module: `sig_lfsr_div`

## Requirements
- R1: While `rst_n` is low, `sig`, `pass` and `vld` are 0 whatever `en` and `din` do. The core stays in reset for at least the first rising edge after `rst_n` goes high.
- R2: A rising edge with `clr`=1 sets `sig` to 0 and `pass` to 0, and suppresses `vld`. This holds even when `en` or `chk` is high in the same cycle.
- R3: A rising edge with `clr`=0 and `en`=0 leaves `sig` unchanged.
- R4: On a rising edge with `clr`=0 and `en`=1, with m = old `sig[WIDTH-1]`: new `sig[0]` = `din` XOR (`TAPS[0]` AND m), and new `sig[i]` = old `sig[i-1]` XOR (`TAPS[i]` AND m) for i ≥ 1.
- R5: `qout` equals `sig[WIDTH-1]`, which is the bit that leaves on the next enabled edge. Over a run of n bits after a clear, the first WIDTH leaving bits are 0. The remaining n−WIDTH bits are the quotient coefficients, highest order first.
- R6: After a clear followed by n enabled edges with the dividend bits on `din` (highest order first), `sig` is the remainder of the dividend modulo the divisor, with `sig[i]` the coefficient of x^i. With WIDTH=3 and TAPS=3'b011 (divisor x^3+x+1), the stream 1,0,0,1,0,1,1 gives `sig`=3'b101 after 7 edges, and the last 4 leaving bits are 1,0,1,0.
- R7: A rising edge with `chk`=1 and `clr`=0 makes `vld`=1 for the next cycle only. `pass` then shows whether `sig` before that edge equalled `EXPECT`, even if `en` shifted the register on the same edge. `pass` holds its value until the next such `chk`, a `clr` or a reset.
- R8: `WIDTH` may be set anywhere from 2 up to 32, which includes the 16- to 32-bit signature range. The defaults are WIDTH=16 and TAPS=16'h8005 (divisor x^16+x^15+x^2+1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of the signature and the verdict |
| en | input | 1 | Shift enable, one input bit per enabled edge |
| din | input | 1 | Serial dividend / response bit |
| chk | input | 1 | Compare strobe |
| qout | output | 1 | Bit leaving the top cell (quotient stream) |
| sig | output | WIDTH | Register state (remainder / signature) |
| vld | output | 1 | One-cycle verdict strobe |
| pass | output | 1 | Signature matched EXPECT at the last compare |

## Verification
Every state bit is visible on `sig`. A wrong feedback tap or a wrong shift path therefore appears at the ports on the very next enabled edge, and the bench compares the whole register after every shifted bit. A bad top cell also corrupts `qout` one cycle before the corrupted bit would re-enter the feedback. A fault in the verdict path appears on `vld` or `pass` in the cycle right after `chk`. This is checked both for matching and for non-matching signatures, and with `chk` coinciding with a shift.

// File: rtl/sig_pkg.sv
package sig_pkg;
  typedef struct packed {
    logic vld;
    logic pass;
  } match_t;
endpackage

// File: rtl/sig_rst_sync.sv
module sig_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/sig_shift_core.sv
module sig_shift_core #(
  parameter int            W    = 16,
  parameter logic [W-1:0]  TAPS = 16'h8005
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] state_q
);
  logic         fb;
  logic [W-1:0] shifted;
  logic [W-1:0] state_d;

  assign fb = state_q[W-1];

  // per-cell next value: previous cell (or serial input) plus optional feedback
  for (genvar i = 0; i < W; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign shifted[i] = din ^ (TAPS[i] & fb);
    end else begin : g_body
      assign shifted[i] = state_q[i-1] ^ (TAPS[i] & fb);
    end
  end

  always_comb begin
    state_d = state_q;
    if (clr)     state_d = '0;
    else if (en) state_d = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/sig_match.sv
module sig_match #(
  parameter int           W      = 16,
  parameter logic [W-1:0] EXPECT = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            chk,
  input  logic [W-1:0]    sig,
  output sig_pkg::match_t res_q
);
  sig_pkg::match_t res_d;

  always_comb begin
    res_d     = res_q;
    res_d.vld = 1'b0;
    if (clr) begin
      res_d = '0;
    end else if (chk) begin
      res_d.vld  = 1'b1;
      res_d.pass = (sig == EXPECT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end
endmodule

// File: rtl/sig_lfsr_div.sv
module sig_lfsr_div #(
  parameter int               WIDTH  = 16,
  parameter logic [WIDTH-1:0] TAPS   = 16'h8005,
  parameter logic [WIDTH-1:0] EXPECT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  input  logic             chk,
  output logic             qout,
  output logic [WIDTH-1:0] sig,
  output logic             vld,
  output logic             pass
);
  logic            core_rst_n;
  logic [WIDTH-1:0] state;
  sig_pkg::match_t  res;

  sig_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  sig_shift_core #(.W(WIDTH), .TAPS(TAPS)) u_core (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .clr     (clr),
    .en      (en),
    .din     (din),
    .state_q (state)
  );

  sig_match #(.W(WIDTH), .EXPECT(EXPECT)) u_match (
    .clk   (clk),
    .rst_n (core_rst_n),
    .clr   (clr),
    .chk   (chk),
    .sig   (state),
    .res_q (res)
  );

  assign sig  = state;
  assign qout = state[WIDTH-1];
  assign vld  = res.vld;
  assign pass = res.pass;
endmodule

// File: rtl/sig_lfsr_div_chk.sv
module sig_lfsr_div_chk #(
  parameter int           W      = 16,
  parameter logic [W-1:0] TAPS   = 16'h8005,
  parameter logic [W-1:0] EXPECT = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         en,
  input logic         din,
  input logic         chk,
  input logic [W-1:0] sig,
  input logic         vld,
  input logic         pass
);
  localparam logic [W-1:0] TM = TAPS;

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (sig == '0 && !pass && !vld);
    end
  end

  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sig == '0) && !pass && !vld);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(sig));

  assert_head_cell_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && en) |=> sig[0] == ($past(din) ^ (TM[0] & $past(sig[W-1]))));

  assert_body_cells_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && en) |=> sig[W-1:1] ==
      ($past(sig[W-2:0]) ^ (TM[W-1:1] & {(W-1){$past(sig[W-1])}})));

  assert_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && !clr) |=> vld && (pass == ($past(sig) == EXPECT)));

  assert_verdict_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk && !clr) |=> !vld);

  assert_verdict_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk && !clr) |=> $stable(pass));
endmodule

bind sig_lfsr_div sig_lfsr_div_chk #(.W(WIDTH), .TAPS(TAPS), .EXPECT(EXPECT)) u_chk (
  .clk   (clk),
  .rst_n (core_rst_n),
  .clr   (clr),
  .en    (en),
  .din   (din),
  .chk   (chk),
  .sig   (sig),
  .vld   (vld),
  .pass  (pass)
);

// File: tb/sim_sig_lfsr_div.sv
module sim_sig_lfsr_div;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  // u0: default 16-bit configuration, expected signature zero
  logic clr0 = 0, en0 = 0, din0 = 0, chk0 = 0;
  logic qout0, vld0, pass0;
  logic [15:0] sig0;
  // u1: 3-bit divider x^3+x+1, expected signature 3'b101
  logic clr1 = 0, en1 = 0, din1 = 0, chk1 = 0;
  logic qout1, vld1, pass1;
  logic [2:0] sig1;

  sig_lfsr_div #(.WIDTH(16), .TAPS(16'h8005), .EXPECT(16'h0000)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr0), .en(en0), .din(din0), .chk(chk0),
    .qout(qout0), .sig(sig0), .vld(vld0), .pass(pass0));

  sig_lfsr_div #(.WIDTH(3), .TAPS(3'b011), .EXPECT(3'b101)) u1 (
    .clk(clk), .rst_n(rst_n), .clr(clr1), .en(en1), .din(din1), .chk(chk1),
    .qout(qout1), .sig(sig1), .vld(vld1), .pass(pass1));

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;
  logic [15:0] m0;
  logic [2:0]  m1;
  logic [6:0]  qbits;

  function automatic logic [15:0] div16(input logic [15:0] r, input logic b);
    logic [16:0] t;
    t = {r, b};
    if (t[16]) t = t ^ 17'h18005;
    return t[15:0];
  endfunction

  function automatic logic [2:0] div3(input logic [2:0] r, input logic b);
    logic [3:0] t;
    t = {r, b};
    if (t[3]) t = t ^ 4'b1011;
    return t[2:0];
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear0();
    clr0 = 1; @(negedge clk); clr0 = 0; m0 = '0;
    check(sig0 == 16'h0, "R2 clear u0", sig0, 0);
  endtask

  task automatic shift0(input logic b);
    check(qout0 == m0[15], "R5 qout u0", qout0, m0[15]);
    en0 = 1; din0 = b;
    @(negedge clk);
    m0 = div16(m0, b);
    check(sig0 == m0, "R6 R4 remainder u0", sig0, m0);
  endtask

  task automatic compare0();
    chk0 = 1; @(negedge clk); chk0 = 0;
    check(vld0 == 1'b1, "R7 vld u0", vld0, 1);
    check(pass0 == (m0 == 16'h0), "R7 pass u0", pass0, (m0 == 16'h0));
    @(negedge clk);
    check(vld0 == 1'b0, "R7 vld pulse u0", vld0, 0);
    check(pass0 == (m0 == 16'h0), "R7 pass hold u0", pass0, (m0 == 16'h0));
  endtask

  task automatic shift1(input logic b, input int idx);
    check(qout1 == m1[2], "R5 qout u1", qout1, m1[2]);
    qbits[6-idx] = qout1;
    en1 = 1; din1 = b;
    @(negedge clk);
    m1 = div3(m1, b);
    check(sig1 == m1, "R6 R4 remainder u1", sig1, m1);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // R1: reset holds everything at zero even with shifting requested
    en0 = 1; din0 = 1; chk0 = 1;
    repeat (3) @(negedge clk);
    check(sig0 == 0, "R1 reset sig", sig0, 0);
    check(pass0 == 0 && vld0 == 0, "R1 reset verdict", {pass0, vld0}, 0);
    rst_n = 1;
    @(negedge clk);
    check(sig0 == 0, "R1 first edge after release", sig0, 0);
    en0 = 0; chk0 = 0; din0 = 0;
    repeat (3) @(negedge clk);
    m0 = '0; m1 = '0;

    // R6 named example on u1: 1001011 -> remainder 101, quotient 1010
    clr1 = 1; @(negedge clk); clr1 = 0; m1 = '0;
    for (int k = 0; k < 7; k++) shift1(((7'b1001011 >> (6 - k)) & 1) != 0, k);
    en1 = 0;
    check(sig1 == 3'b101, "R6 example remainder", sig1, 3'b101);
    check(qbits == 7'b0001010, "R5 example quotient", qbits, 7'b0001010);
    chk1 = 1; @(negedge clk); chk1 = 0;
    check(vld1 && pass1, "R7 example pass", {vld1, pass1}, 2'b11);

    // exhaustive sweep of all 7-bit dividends on u1
    for (int v = 0; v < 128; v++) begin
      clr1 = 1; @(negedge clk); clr1 = 0; m1 = '0;
      check(sig1 == 0, "R2 clear u1", sig1, 0);
      for (int k = 0; k < 7; k++) shift1(((v >> (6 - k)) & 1) != 0, k);
      en1 = 0;
      check(qbits[6:4] == 3'b000, "R5 leading zeros u1", qbits[6:4], 0);
      chk1 = 1; @(negedge clk); chk1 = 0;
      check(vld1 == 1, "R7 vld u1", vld1, 1);
      check(pass1 == (m1 == 3'b101), "R7 pass u1", pass1, (m1 == 3'b101));
    end

    // R8: default width, divisor stream itself gives zero remainder
    clear0();
    for (int k = 16; k >= 0; k--) shift0(((17'h18005 >> k) & 1) != 0);
    en0 = 0;
    check(sig0 == 16'h0, "R8 R6 divisor mod itself", sig0, 0);
    compare0();
    check(pass0 == 1, "R7 match u0", pass0, 1);

    // R2: clear drops pass and wins over en
    clr0 = 1; en0 = 1; din0 = 1; @(negedge clk); clr0 = 0; en0 = 0; m0 = '0;
    check(sig0 == 0 && pass0 == 0, "R2 clear priority", {sig0, pass0}, 0);

    // R7: chk on a shifting edge compares the pre-shift state
    for (int k = 16; k >= 0; k--) shift0(((17'h18005 >> k) & 1) != 0);
    chk0 = 1; din0 = 1; en0 = 1; @(negedge clk); chk0 = 0; en0 = 0;
    m0 = div16(m0, 1'b1);
    check(vld0 && pass0, "R7 chk with shift verdict", {vld0, pass0}, 2'b11);
    check(sig0 == 16'h0001, "R7 chk with shift state", sig0, 16'h0001);

    // random streams of varying lengths
    for (int s = 0; s < 40; s++) begin
      int len;
      len = 16 + ($urandom % 80);
      clear0();
      for (int k = 0; k < len; k++) shift0(($urandom & 1) != 0);
      en0 = 0;
      // R3: idle cycles hold the state
      repeat (4) @(negedge clk);
      check(sig0 == m0, "R3 hold", sig0, m0);
      compare0();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule